// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This engine moves outgoing packet data from memory to a byte stream under the control of descriptors that software keeps in memory. Each of the two transmit queues has a head pointer. When a queue is kicked, the engine starts at that head and follows the chain of descriptors until it comes back to the head. Every descriptor that is marked as owned by hardware has its buffer streamed out byte by byte. The engine then returns the descriptor to software by clearing the ownership bit in memory, and it raises a queue-specific completion cause.

Memory is reached through one word-wide master port with a request/grant handshake. The stream side is a valid/ready byte port with an end-of-buffer marker. Descriptors whose length is zero or too large for a buffer are retired without being streamed. A bound on the number of descriptors visited in one sweep protects the engine against rings that never close.

Top module: `txdesc_ring_dma`

## Requirements
- R1: A descriptor occupies four 32-bit words at byte offsets 0, 4, 8 and 12 from its address. Word 0 is command/status, with bit 31 as the ownership flag. Word 1 carries the byte count in bits 31:16, and its bits 15:0 are ignored. Word 2 is the buffer byte address. Word 3 is the address of the next descriptor.
- R2: A descriptor whose bit 31 is clear is neither streamed nor written, and the walk continues with its next descriptor.
- R3: For an owned descriptor with a count between 1 and MAX_LEN-1, the engine streams exactly count bytes in ascending address order. The byte at address A is bits [8*(A mod 4)+7 : 8*(A mod 4)] of the memory word at A rounded down to a multiple of 4. tx_last is high on the final byte only.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values in the next cycle.
- R5: An owned descriptor with a count of 0 or of MAX_LEN (2048) or more streams no byte, but it is still written back and still raises its cause.
- R6: After an owned descriptor has been handled, exactly one write goes to its word 0. That write carries the original word with bit 31 cleared and every other bit unchanged.
- R7: Each written-back descriptor gives a one-cycle pulse on cause_set. The pulse is bit 3 for queue 0 and bit 2 for queue 1, and bits 1:0 never pulse.
- R8: A sweep latches the queue's head pointer when it starts and follows the next fields. It ends after the descriptor whose next address equals that head, so every descriptor of a closed ring is visited once, starting at the head.
- R9: A sweep ends after MAX_STEPS (256) descriptors even if the ring never returns to its head.
- R10: Kicks are remembered, including kicks that arrive during a sweep. When both queues are pending, queue 1 is swept completely before queue 0 starts.
- R11: A memory request holds mem_addr, mem_we and mem_wdata stable until mem_gnt is high. Read data is taken from mem_rdata in the grant cycle.
- R12: After reset, and whenever busy is low, there is no memory request, no stream output and no cause pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 2 | One-cycle start pulse per queue (bit 0 queue 0, bit 1 queue 1) |
| q0_head | input | 32 | Head descriptor address of queue 0 |
| q1_head | input | 32 | Head descriptor address of queue 1 |
| busy | output | 1 | A sweep is in progress |
| cause_set | output | 4 | One-cycle completion cause pulses |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the buffer |
| tx_ready | input | 1 | Stream sink accepts the byte |

## Verification
The hardest situation to reach is a ring that never closes, because that is the only case in which the step bound ends a sweep. The bench builds a two-descriptor chain whose second entry points to itself and checks the exact number of word reads: four per visit for 256 visits, plus the single buffer read of the one owned entry, which is released on its first visit. Queue ordering needs kicks that coincide or overlap. The bench raises both kicks in the same cycle, and it raises a queue 0 kick in the middle of a queue 1 sweep. Both grant and ready follow a pseudo-random pattern throughout, so the hold rules are exercised on every transfer.

// File: rtl/txr_pkg.sv
package txr_pkg;

    parameter int WORD_W     = 32;
    parameter int ADDR_W     = 32;
    parameter int BYTE_W     = 8;
    parameter int CNT_W      = 16;
    parameter int CNT_LSB    = 16;
    parameter int OWN_BIT    = 31;
    parameter int DESC_WORDS = 4;
    parameter int NQ         = 2;
    parameter int CAUSE_W    = 4;
    parameter int CAUSE_TOP  = 3;

    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = $clog2(DESC_WORDS);
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECIDE,
        S_BREAD,
        S_SEND,
        S_WBACK,
        S_ADV
    } walk_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] buf_addr;
        logic [ADDR_W-1:0] nxt;
    } tx_desc_t;

    function automatic logic [CAUSE_W-1:0] cause_for_queue(input logic [QW-1:0] q);
        logic [CAUSE_W-1:0] m;
        m = '0;
        m[CAUSE_TOP - int'(q)] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] release_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[OWN_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        r[LANE_W-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/txr_kick_sched.sv
module txr_kick_sched #(
    parameter int NQ = 2,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] kick,
    input  logic          take,
    input  logic [QW-1:0] take_q,
    output logic          any,
    output logic [QW-1:0] pick
);

    logic [NQ-1:0] pend;

    for (genvar g = 0; g < NQ; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
            end else if (kick[g]) begin
                pend[g] <= 1'b1;
            end else if (take && (take_q == QW'(g))) begin
                pend[g] <= 1'b0;
            end
        end
    end

    // Highest-numbered pending queue wins.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NQ; i++) begin
            if (pend[i]) pick = QW'(i);
        end
    end

    assign any = |pend;

endmodule

// File: rtl/txr_step_guard.sv
module txr_step_guard #(
    parameter int MAX_STEPS = 256,
    localparam int CW = $clog2(MAX_STEPS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic last_step
);

    logic [CW-1:0] visits;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            visits <= '0;
        end else if (inc) begin
            visits <= visits + 1'b1;
        end
    end

    assign last_step = (visits == CW'(MAX_STEPS - 1));

endmodule

// File: rtl/txr_lane_pick.sv
module txr_lane_pick #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[lane];

endmodule

// File: rtl/txdesc_ring_dma.sv
module txdesc_ring_dma
    import txr_pkg::*;
#(
    parameter int MAX_LEN   = 2048,
    parameter int MAX_STEPS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NQ-1:0]        kick,
    input  logic [ADDR_W-1:0]    q0_head,
    input  logic [ADDR_W-1:0]    q1_head,
    output logic                 busy,
    output logic [CAUSE_W-1:0]   cause_set,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_gnt,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 tx_valid,
    output logic [BYTE_W-1:0]    tx_data,
    output logic                 tx_last,
    input  logic                 tx_ready
);

    walk_st_e            st;
    logic [QW-1:0]       cur_q;
    logic [ADDR_W-1:0]   head_q;
    logic [ADDR_W-1:0]   dptr;
    logic [IDX_W-1:0]    widx;
    tx_desc_t            desc;
    logic [CNT_W-1:0]    bidx;
    logic [WORD_W-1:0]   word_q;
    logic [CAUSE_W-1:0]  cause_q;

    logic                sch_any;
    logic [QW-1:0]       sch_pick;
    logic                start;
    logic                last_step;
    logic [ADDR_W-1:0]   baddr;
    logic                cnt_ok;
    logic                final_byte;
    logic [BYTE_W-1:0]   lane_byte;

    assign start      = (st == S_IDLE) && sch_any;
    assign baddr      = desc.buf_addr + ADDR_W'(bidx);
    assign cnt_ok     = (desc.count != '0) && (int'(desc.count) < MAX_LEN);
    assign final_byte = (bidx == desc.count - 1'b1);

    txr_kick_sched #(.NQ(NQ)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .kick   (kick),
        .take   (start),
        .take_q (sch_pick),
        .any    (sch_any),
        .pick   (sch_pick)
    );

    txr_step_guard #(.MAX_STEPS(MAX_STEPS)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .inc       (st == S_ADV),
        .last_step (last_step)
    );

    txr_lane_pick #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
        .word   (word_q),
        .lane   (baddr[LANE_W-1:0]),
        .byte_o (lane_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cur_q   <= '0;
            head_q  <= '0;
            dptr    <= '0;
            widx    <= '0;
            desc    <= '0;
            bidx    <= '0;
            word_q  <= '0;
            cause_q <= '0;
        end else begin
            cause_q <= '0;
            unique case (st)
                S_IDLE: begin
                    if (sch_any) begin
                        cur_q  <= sch_pick;
                        head_q <= (sch_pick != '0) ? q1_head : q0_head;
                        dptr   <= (sch_pick != '0) ? q1_head : q0_head;
                        widx   <= '0;
                        st     <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_gnt) begin
                        unique case (widx)
                            2'd0: desc.cmd      <= mem_rdata;
                            2'd1: desc.count    <= mem_rdata[CNT_LSB +: CNT_W];
                            2'd2: desc.buf_addr <= mem_rdata;
                            default: desc.nxt   <= mem_rdata;
                        endcase
                        widx <= widx + 1'b1;
                        if (widx == IDX_W'(DESC_WORDS - 1)) st <= S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    if (!desc.cmd[OWN_BIT]) begin
                        st <= S_ADV;
                    end else if (!cnt_ok) begin
                        st <= S_WBACK;
                    end else begin
                        bidx <= '0;
                        st   <= S_BREAD;
                    end
                end
                S_BREAD: begin
                    if (mem_gnt) begin
                        word_q <= mem_rdata;
                        st     <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (tx_ready) begin
                        if (final_byte) begin
                            st <= S_WBACK;
                        end else begin
                            bidx <= bidx + 1'b1;
                            if (baddr[LANE_W-1:0] == '1) st <= S_BREAD;
                        end
                    end
                end
                S_WBACK: begin
                    if (mem_gnt) begin
                        cause_q <= cause_for_queue(cur_q);
                        st      <= S_ADV;
                    end
                end
                default: begin
                    if ((desc.nxt == head_q) || last_step) begin
                        st <= S_IDLE;
                    end else begin
                        dptr <= desc.nxt;
                        widx <= '0;
                        st   <= S_FETCH;
                    end
                end
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dptr + ADDR_W'({widx, 2'b00});
            end
            S_BREAD: begin
                mem_req  = 1'b1;
                mem_addr = word_align(baddr);
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dptr;
                mem_wdata = release_word(desc.cmd);
            end
            default: ;
        endcase
    end

    assign busy      = (st != S_IDLE);
    assign cause_set = cause_q;
    assign tx_valid  = (st == S_SEND);
    assign tx_data   = tx_valid ? lane_byte : '0;
    assign tx_last   = tx_valid && final_byte;

endmodule

// File: rtl/txdesc_ring_dma_chk.sv
module txdesc_ring_dma_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [3:0]  cause_set,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_gnt,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        tx_ready
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[31]); // R6

    AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause_set) && (cause_set[1:0] == 2'b00)); // R7

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !tx_valid && (cause_set == 4'd0)); // R12

endmodule

bind txdesc_ring_dma txdesc_ring_dma_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .cause_set (cause_set),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready)
);

// File: tb/txdesc_ring_dma_tb.sv
module txdesc_ring_dma_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MEMW       = 1024;
    localparam logic [31:0] OWN = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  kick;
    logic [31:0] q0_head, q1_head;
    logic        busy;
    logic [3:0]  cause_set;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;

    logic [31:0] mem [0:MEMW-1];

    txdesc_ring_dma u_dut (
        .clk(clk), .rst(rst), .kick(kick), .q0_head(q0_head), .q1_head(q1_head),
        .busy(busy), .cause_set(cause_set),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (mem_req && mem_gnt && mem_we) mem[mem_addr[11:2]] <= mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [7:0] exp_b [0:8191];
    bit         exp_l [0:8191];
    int exp_n, got_n, rd_cnt, wr_cnt, c3_cnt, c2_cnt;
    logic [3:0] first_cause;
    bit prev_stall, prev_wait, prev_we, prev_last;
    logic [7:0] prev_data;
    logic [31:0] prev_addr;
    logic [15:0] lfsr = 16'hACE1;

    int  cnt_a [0:15];
    bit  own_a [0:15];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 13 + (a >> 4) + 1);
    endfunction

    task automatic init_mem();
        for (int w = 0; w < MEMW; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    endtask

    function automatic int buf_of(input int bbase, input int i);
        return bbase + 64*i + (i % 4);
    endfunction

    function automatic logic [31:0] cmd_of(input int i);
        return (own_a[i] ? OWN : 32'h0) | 32'h0000_5A00 | 32'(i);
    endfunction

    task automatic build(input int dbase, input int bbase, input int n, input int step);
        for (int i = 0; i < n; i++) begin
            int d = (dbase + 16*i) / 4;
            mem[d]   = cmd_of(i);
            mem[d+1] = {16'(cnt_a[i]), 16'hBEEF};
            mem[d+2] = 32'(buf_of(bbase, i));
            mem[d+3] = 32'(dbase + 16*((i + step) % n));
        end
    endtask

    task automatic expect_walk(input int bbase, input int n, input int step, input int h);
        int idx = h;
        for (int k = 0; k < n; k++) begin
            if (own_a[idx] && cnt_a[idx] > 0 && cnt_a[idx] < 2048) begin
                for (int b = 0; b < cnt_a[idx]; b++) begin
                    exp_b[exp_n] = pat(buf_of(bbase, idx) + b);
                    exp_l[exp_n] = (b == cnt_a[idx] - 1);
                    exp_n++;
                end
            end
            idx = (idx + step) % n;
        end
    endtask

    task automatic check_wb(input int dbase, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [31:0] e = own_a[i] ? (cmd_of(i) & ~OWN) : cmd_of(i);
            chk(mem[(dbase + 16*i)/4] == e, req, "descriptor word0 after sweep",
                mem[(dbase + 16*i)/4], e);
        end
    endtask

    function automatic int owned(input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (own_a[i]) c++;
        return c;
    endfunction

    task automatic clear_stats();
        exp_n = 0; got_n = 0; rd_cnt = 0; wr_cnt = 0; c3_cnt = 0; c2_cnt = 0;
        first_cause = 4'd0;
    endtask

    task automatic pulse(input logic [1:0] k);
        @(negedge clk); kick = k;
        @(negedge clk); kick = 2'b00;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (3) @(negedge clk);
        while (quiet < 4) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    task automatic stream_done(input string req);
        chk(got_n == exp_n, req, "streamed byte total", got_n, exp_n);
    endtask

    // Stimulus for grant/ready and monitoring, all away from the active edge.
    initial begin
        mem_gnt = 1'b0; tx_ready = 1'b0;
        prev_stall = 0; prev_wait = 0;
        forever begin
            @(negedge clk);
            cycles++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_gnt  = lfsr[0] | lfsr[1];
            tx_ready = lfsr[2] | lfsr[5];
            #1;
            if (!rst) begin
                if (prev_stall)
                    chk(tx_valid && tx_data == prev_data && tx_last == prev_last, "R4",
                        "stream hold under back-pressure", tx_data, prev_data);
                if (prev_wait)
                    chk(mem_req && mem_addr == prev_addr && mem_we == prev_we, "R11",
                        "request hold until grant", mem_addr, prev_addr);
                if (tx_valid && tx_ready) begin
                    if (got_n < exp_n) begin
                        chk(tx_data == exp_b[got_n], "R3", "stream byte", tx_data, exp_b[got_n]);
                        chk(tx_last == exp_l[got_n], "R3", "last flag", tx_last, exp_l[got_n]);
                    end else begin
                        chk(1'b0, "R3", "unexpected extra byte", got_n, exp_n);
                    end
                    got_n++;
                end
                if (mem_req && mem_gnt) begin
                    if (mem_we) wr_cnt++; else rd_cnt++;
                end
                if (cause_set[3]) c3_cnt++;
                if (cause_set[2]) c2_cnt++;
                if (cause_set[1:0] != 2'b00)
                    chk(1'b0, "R7", "low cause bits pulsed", cause_set, 0);
                if (first_cause == 4'd0 && cause_set != 4'd0) first_cause = cause_set;
                prev_stall = tx_valid && !tx_ready;
                prev_data  = tx_data;
                prev_last  = tx_last;
                prev_wait  = mem_req && !mem_gnt;
                prev_addr  = mem_addr;
                prev_we    = mem_we;
            end
        end
    end

    initial begin
        wait (cycles > 150000);
        chk(1'b0, "WATCHDOG", "run did not finish", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; kick = 2'b00; q0_head = 32'h100; q1_head = 32'h400;
        init_mem();
        clear_stats();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // R12: quiet after reset
        chk(!busy && !mem_req && !tx_valid && cause_set == 4'd0, "R12", "reset state",
            {busy, mem_req, tx_valid, cause_set}, 0);

        // R1 R3 R6 R7 R8: 12-entry ring, counts 1..12, all four buffer offsets, stride-5 chain, head 3
        for (int i = 0; i < 12; i++) begin cnt_a[i] = i + 1; own_a[i] = (i % 3 != 1); end
        clear_stats();
        build(32'h100, 32'h800, 12, 5);
        q0_head = 32'h100 + 16*3;
        expect_walk(32'h800, 12, 5, 3);
        pulse(2'b01);
        wait_idle();
        stream_done("R1");
        chk(c3_cnt == owned(12), "R7", "queue0 cause pulses", c3_cnt, owned(12));
        chk(c2_cnt == 0, "R7", "queue1 cause pulses", c2_cnt, 0);
        chk(wr_cnt == owned(12), "R6", "writeback count", wr_cnt, owned(12));
        check_wb(32'h100, 12, "R2");

        // R8: sweep of the head position over a 6-entry ring
        for (int h = 0; h < 6; h++) begin
            for (int i = 0; i < 6; i++) begin cnt_a[i] = 1 + ((i + h) % 5); own_a[i] = ((i + h) % 4 != 0); end
            clear_stats();
            build(32'h100, 32'h800, 6, 1);
            q0_head = 32'h100 + 16*h;
            expect_walk(32'h800, 6, 1, h);
            pulse(2'b01);
            wait_idle();
            stream_done("R8");
            chk(wr_cnt == owned(6), "R8", "each descriptor visited once", wr_cnt, owned(6));
        end

        // R5: zero and oversize counts on queue 1
        cnt_a[0] = 2048; cnt_a[1] = 0; cnt_a[2] = 5; cnt_a[3] = 40000;
        for (int i = 0; i < 4; i++) own_a[i] = 1;
        clear_stats();
        build(32'h400, 32'hC00, 4, 1);
        q1_head = 32'h400;
        expect_walk(32'hC00, 4, 1, 0);
        pulse(2'b10);
        wait_idle();
        stream_done("R5");
        chk(c2_cnt == 4, "R5", "oversize still raise cause bit 2", c2_cnt, 4);
        chk(c3_cnt == 0, "R7", "no queue0 cause", c3_cnt, 0);
        chk(wr_cnt == 4, "R5", "oversize still written back", wr_cnt, 4);
        check_wb(32'h400, 4, "R5");

        // R10: both kicks in one cycle, queue 1 first
        for (int i = 0; i < 3; i++) begin cnt_a[i] = 3 + i; own_a[i] = 1; end
        clear_stats();
        build(32'h400, 32'hC00, 3, 1);
        build(32'h100, 32'h800, 3, 1);
        q0_head = 32'h100; q1_head = 32'h400;
        expect_walk(32'hC00, 3, 1, 0);
        expect_walk(32'h800, 3, 1, 0);
        pulse(2'b11);
        wait_idle();
        stream_done("R10");
        chk(first_cause == 4'b0100, "R10", "first completion is queue 1", first_cause, 4'b0100);
        chk(c2_cnt == 3 && c3_cnt == 3, "R10", "both queues completed", {c2_cnt[7:0], c3_cnt[7:0]}, 16'h0303);

        // R10: queue 0 kicked while queue 1 sweep is running
        for (int i = 0; i < 3; i++) begin cnt_a[i] = 20 + i; own_a[i] = 1; end
        clear_stats();
        build(32'h400, 32'hC00, 3, 1);
        build(32'h100, 32'h800, 3, 1);
        expect_walk(32'hC00, 3, 1, 0);
        expect_walk(32'h800, 3, 1, 0);
        pulse(2'b10);
        repeat (6) @(negedge clk);
        #2;
        chk(busy == 1'b1, "R10", "busy during queue 1 sweep", busy, 1);
        pulse(2'b01);
        wait_idle();
        stream_done("R10");
        chk(first_cause == 4'b0100, "R10", "kick during busy kept order", first_cause, 4'b0100);
        chk(c3_cnt == 3, "R10", "late queue 0 kick served", c3_cnt, 3);

        // R9: chain that never returns to its head; second entry loops on itself
        clear_stats();
        mem[32'h100/4]   = 32'h0000_0011;
        mem[32'h100/4+1] = {16'd4, 16'h0};
        mem[32'h100/4+2] = 32'h800;
        mem[32'h100/4+3] = 32'h110;
        mem[32'h110/4]   = OWN | 32'h22;
        mem[32'h110/4+1] = {16'd3, 16'h0};
        mem[32'h110/4+2] = 32'h900;
        mem[32'h110/4+3] = 32'h110;
        for (int b = 0; b < 3; b++) begin
            exp_b[exp_n] = pat(32'h900 + b); exp_l[exp_n] = (b == 2); exp_n++;
        end
        q0_head = 32'h100;
        pulse(2'b01);
        wait_idle();
        stream_done("R9");
        chk(rd_cnt == 256*4 + 1, "R9", "reads in bounded sweep", rd_cnt, 256*4 + 1);
        chk(wr_cnt == 1 && c3_cnt == 1, "R9", "single release in loop", wr_cnt, 1);
        chk(mem[32'h110/4] == 32'h22, "R6", "looped entry released", mem[32'h110/4], 32'h22);
        chk(mem[32'h100/4] == 32'h11, "R2", "unowned entry untouched", mem[32'h100/4], 32'h11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule